// File: doc/BRIEF.md
# Packet Bit-Stream Whitener

This block sits in the serial bit path of a packet radio and scrambles the header and payload bits, CRC bits included, by XOR with a pseudo-random key stream. Scrambling breaks up long runs and repeated patterns in the data and keeps the line free of DC bias. XOR is its own inverse, so the same block whitens on the transmit side and restores the data on the receive side, provided both ends start from the same seed.

The key stream comes from a 7-stage linear feedback shift register with polynomial x^7 + x^4 + 1. A single software-written seed register sets the starting state. The same register also serves as the on/off control: a zero seed disables scrambling and the bits pass through unchanged. The block has no enable bit and reports no status. A header-start strobe marks the first bit of each packet and reloads the generator from the seed. A seed write that lands in the middle of a packet therefore applies only from the next packet onward.

Top module: `pkt_whitener`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` and `out_bit` are 0, the seed register holds zero and the generator state is zero. Valid bits sent before the first header strobe therefore pass through unchanged.
- R2: Each bit presented with `in_valid` high appears on `out_bit` one clock later, with `out_valid` high in that cycle. `out_valid` is `in_valid` delayed by exactly one cycle.
- R3: The key bit for a valid input bit is the most significant stage (bit 6) of the effective state. The effective state is the seed register on a `hdr_start` cycle and the generator state otherwise. After each valid bit the state becomes {state[5:0], state[6] ^ state[3]}. With seed 7'h7F, the first eight key bits are 1,1,1,1,1,1,1,0.
- R4: When the effective state is all zeros (zero seed), every valid output bit equals its input bit.
- R5: A seed write (`cfg_we` high) updates the seed register on the next clock edge. It does not alter the key stream of the packet in progress. A write in the same cycle as `hdr_start` does not affect that packet; the strobe uses the previously stored seed.
- R6: Passing a whitened packet through the block a second time with the same seed restores the original bits.
- R7: Every `hdr_start` restarts the key stream from the stored seed. Two packets sent with the same seed and data give identical output.
- R8: Cycles with `in_valid` low do not advance the generator, and the cycle after them shows `out_valid` = 0 and `out_bit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Seed register write strobe |
| cfg_seed | input | LFSR_W | Seed value to store; zero means bypass |
| hdr_start | input | 1 | Marks the first bit of a packet header; reloads the generator |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit qualifier, one cycle after `in_valid` |
| out_bit | output | 1 | Whitened (or de-whitened) bit |

## Verification
The bench stretches packets with idle gaps. A generator that advanced on idle cycles would misalign the key stream from the first gap onward. It writes the seed mid-packet and in the very cycle of the header strobe. A design that applied the new seed at once, or let the same-cycle write win, would corrupt the rest of that packet. A zero seed written in mid-packet must keep scrambling until the next strobe and then pass data through untouched. A fixed key prefix for a known seed and a round trip through the block expose a wrong tap or a wrong output stage, which a model-only comparison could share.

// File: rtl/pkt_whiten_pkg.sv
package pkt_whiten_pkg;

   // Default generator width and feedback taps (stages 6 and 3: x^7 + x^4 + 1)
   localparam int              DEF_LFSR_W = 7;
   localparam logic [6:0]      DEF_TAPS   = 7'b100_1000;

   // Keyed bit with its qualifier, as carried into the output stage
   typedef struct packed {
      logic vld;
      logic dat;
   } wbit_t;

endpackage

// File: rtl/whiten_seed_reg.sv
module whiten_seed_reg #(
   parameter int LFSR_W = pkt_whiten_pkg::DEF_LFSR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LFSR_W-1:0] wdata,
   output logic [LFSR_W-1:0] seed_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  seed_q <= '0;
      else if (we) seed_q <= wdata;
   end

   AST_SEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(seed_q)); // R5

   AST_SEED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (seed_q == $past(wdata))); // R5

endmodule

// File: rtl/whiten_lfsr.sv
module whiten_lfsr #(
   parameter int                LFSR_W   = pkt_whiten_pkg::DEF_LFSR_W,
   parameter logic [LFSR_W-1:0] TAP_MASK = pkt_whiten_pkg::DEF_TAPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LFSR_W-1:0] seed,
   input  logic              adv,
   output logic              key_bit,
   output logic [LFSR_W-1:0] eff_state
);

   localparam int MSB = LFSR_W - 1;

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] stepped;
   logic [LFSR_W-1:0] state_d;
   logic              fb;

   initial begin
      assert (LFSR_W >= 2) else $fatal(1, "whiten_lfsr: LFSR_W must be at least 2");
      assert (TAP_MASK[MSB]) else $fatal(1, "whiten_lfsr: top stage must be tapped");
   end

   assign eff_state = load ? seed : state_q;
   assign key_bit   = eff_state[MSB];
   assign fb        = ^(eff_state & TAP_MASK);

   generate
      for (genvar i = 0; i < LFSR_W; i++) begin : g_stage
         if (i == 0) begin : g_fb
            assign stepped[i] = fb;
         end else begin : g_shift
            assign stepped[i] = eff_state[i-1];
         end
      end
   endgenerate

   assign state_d = adv ? stepped : eff_state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_d;
   end

   AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(state_q)); // R8

   AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !adv) |=> (state_q == $past(seed))); // R7

   AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == '0 && !load) |=> (state_q == '0)); // R4

endmodule

// File: rtl/whiten_xor_stage.sv
module whiten_xor_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   input  logic key_bit,
   output logic out_valid,
   output logic out_bit
);
   import pkt_whiten_pkg::*;

   wbit_t nxt, cur;

   always_comb begin
      nxt.vld = in_valid;
      nxt.dat = in_valid & (in_bit ^ key_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= '0;
      else        cur <= nxt;
   end

   assign out_valid = cur.vld;
   assign out_bit   = cur.dat;

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_bit)); // R8

endmodule

// File: rtl/pkt_whitener.sv
module pkt_whitener #(
   parameter int                LFSR_W   = pkt_whiten_pkg::DEF_LFSR_W,
   parameter logic [LFSR_W-1:0] TAP_MASK = pkt_whiten_pkg::DEF_TAPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [LFSR_W-1:0] cfg_seed,
   input  logic              hdr_start,
   input  logic              in_valid,
   input  logic              in_bit,
   output logic              out_valid,
   output logic              out_bit
);

   logic [LFSR_W-1:0] seed_q;
   logic [LFSR_W-1:0] eff_state;
   logic              key_bit;

   whiten_seed_reg #(.LFSR_W(LFSR_W)) u_seed (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wdata  (cfg_seed),
      .seed_q (seed_q)
   );

   whiten_lfsr #(.LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK)) u_lfsr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (hdr_start),
      .seed      (seed_q),
      .adv       (in_valid),
      .key_bit   (key_bit),
      .eff_state (eff_state)
   );

   whiten_xor_stage u_xor (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .key_bit   (key_bit),
      .out_valid (out_valid),
      .out_bit   (out_bit)
   );

   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && eff_state == '0) |=> (out_bit == $past(in_bit))); // R4

endmodule

// File: tb/pkt_whitener_tb.sv
`timescale 1ns/1ps
module pkt_whitener_tb;

   localparam int W = 7;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_we;
   logic [W-1:0] cfg_seed;
   logic         hdr_start;
   logic         in_valid;
   logic         in_bit;
   logic         out_valid;
   logic         out_bit;

   always #2 clk = ~clk;

   pkt_whitener u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_seed  (cfg_seed),
      .hdr_start (hdr_start),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .out_valid (out_valid),
      .out_bit   (out_bit)
   );

   // {seed, data (bit 15 sent first), gap mask: 1 = idle cycle before that bit}
   localparam logic [38:0] VEC [6] = '{
      {7'h7F, 16'h0000, 16'h0000},
      {7'h55, 16'hFFFF, 16'h0000},
      {7'h00, 16'hA5C3, 16'h0000},
      {7'h01, 16'h1234, 16'h0F00},
      {7'h3C, 16'hDEAD, 16'h8421},
      {7'h40, 16'hBEEF, 16'hFFFF}
   };

   int           n_cmp = 0;
   int           n_bad = 0;
   logic [W-1:0] m_seed;
   logic [W-1:0] m_st;
   logic [15:0]  rec;
   int           rec_n;

   function automatic logic [W-1:0] nx(input logic [W-1:0] s);
      return {s[W-2:0], s[6] ^ s[3]};
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // One clock: drive after a falling edge, check at the next falling edge
   task automatic cyc(input logic sop, input logic vld, input logic b,
                      input logic we, input logic [W-1:0] wd, input string req);
      logic [W-1:0] eff;
      logic         key;
      hdr_start = sop; in_valid = vld; in_bit = b; cfg_we = we; cfg_seed = wd;
      eff  = sop ? m_seed : m_st;
      key  = eff[W-1];
      m_st = vld ? nx(eff) : eff;
      if (we) m_seed = wd;
      @(negedge clk);
      chk({req, " valid"}, out_valid, vld);
      if (vld) begin
         chk(req, out_bit, b ^ key);
         if (rec_n < 16) begin
            rec[15 - rec_n] = out_bit;
            rec_n++;
         end
      end else begin
         chk("R8 idle", out_bit, 1'b0);
      end
   endtask

   task automatic send16(input logic [15:0] d, input logic [15:0] gaps, input string req);
      rec_n = 0;
      for (int i = 15; i >= 0; i--) begin
         if (gaps[i]) cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
         cyc(i == 15, 1'b1, d[i], 1'b0, '0, req);
      end
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
   endtask

   task automatic wr(input logic [W-1:0] s);
      cyc(1'b0, 1'b0, 1'b0, 1'b1, s, "R5");
   endtask

   initial begin
      #400000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [15:0] d0, w0, w1;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_seed = '0; hdr_start = 1'b0;
      in_valid = 1'b0; in_bit = 1'b0;
      m_seed = '0; m_st = '0; rec = '0; rec_n = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset valid", out_valid, 1'b0);
      chk("R1 reset bit", out_bit, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post-reset valid", out_valid, 1'b0);
      // R1 / R4: zero state before any strobe passes data through
      cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, "R1 pass");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R1 pass");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");

      // Table walk: R2 R3 R4 R8
      for (int k = 0; k < 6; k++) begin
         wr(VEC[k][38:32]);
         send16(VEC[k][31:16], VEC[k][15:0], "R2/R3");
         if (VEC[k][38:32] == '0) chk("R4 bypass word", rec == VEC[k][31:16], 1'b1);
      end

      // R3: fixed key prefix for seed 7F, independent of the model
      wr(7'h7F);
      send16(16'h0000, 16'h0000, "R3");
      for (int i = 0; i < 8; i++)
         chk("R3 key prefix", rec[15 - i], (i < 7) ? 1'b1 : 1'b0);

      // R5: write mid-packet does not disturb the packet
      wr(7'h2A);
      rec_n = 0;
      cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, "R5");
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, i[0], 1'b0, '0, "R5");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 7'h11, "R5 mid write");
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, i[1], 1'b0, '0, "R5");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
      // R7: next strobe picks up the new seed
      send16(16'hC0DE, 16'h0000, "R7 new seed");

      // R5: write in the same cycle as the strobe; old seed 11 governs
      rec_n = 0;
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 7'h05, "R5 same-cycle");
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R5 same-cycle");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");

      // R4 / R5: zero written mid-packet; scrambling continues, then bypass
      wr(7'h33);
      rec_n = 0;
      cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, "R5");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 7'h00, "R5 zero write");
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R5");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
      send16(16'h6B29, 16'h0000, "R4");
      chk("R4 bypass after zero", rec == 16'h6B29, 1'b1);

      // R6: round trip restores data
      wr(7'h5B);
      d0 = 16'h9E37;
      send16(d0, 16'h0000, "R6 pass1");
      w0 = rec;
      send16(w0, 16'h0000, "R6 pass2");
      chk("R6 round trip", rec == d0, 1'b1);

      // R7: same seed and data give the same output
      send16(d0, 16'h0000, "R7 repeat");
      w1 = rec;
      chk("R7 repeatable", w1 == w0, 1'b1);

      summary();
   end

endmodule